// File: doc/BRIEF.md
# Streaming Blackman Window Multiplier

This block sits in front of an FFT. It scales each sample of a block of input samples by the Blackman window value for that sample's position in the block. It does not read the window from a stored table. The two cosine terms of the window are generated at run time by two pipelined CORDIC rotators in series. The first rotator turns a vector by the sample's phase, giving cos φ. The second rotator turns that result by the same angle again, giving cos 2φ. Both terms are combined with the fixed window constants into a 16-bit coefficient. Each sample, delayed to line up with its coefficient, is multiplied by it, and the product is rounded and saturated to 16 bits.

The host programs the window length N and a phase step equal to one turn divided by N−1, scaled to the width of the phase accumulator. The host computes the step, so the hardware needs no divider. A configuration write lands in a holding register and may occur at any time. The holding values become active at the next block start, so a window already in progress is never altered. The pipeline accepts one sample every clock cycle and has a fixed latency of 2·STAGES+2 cycles.

Top module: `blackman_cordic_win`

## Requirements
- R1: A sample accepted with `in_valid` in cycle k produces `out_valid` in cycle k+2·STAGES+2, which is cycle k+34 at the default STAGES=16. Back-to-back inputs give back-to-back outputs, and no output appears without an input.
- R2: The output for a sample x at block position n is round(x·w(n)) within ±6 LSB. Here w(n) = 0.42 − 0.5·cos(2πθ) + 0.08·cos(4πθ), and θ = (n·step mod 2^32)/2^32 turns.
- R3: A valid sample with `in_start` high has position 0 and phase 0. Each later valid sample advances the position by one and the phase by the step. After position N−1 both wrap to 0. A new start in the middle of a block restarts at 0.
- R4: A configuration write (`cfg_we` with `cfg_len`, `cfg_step`) does not change the window of the block in progress. It takes effect at the next sample carrying `in_start`. A write in the same cycle as a start applies to the block that starts in that cycle.
- R5: Cycles with `in_valid` low do not advance the position or the phase, and they produce no output.
- R6: Full-scale inputs of either sign (32767, −32768) give outputs that meet R2 and never wrap past the 16-bit signed range.
- R7: While reset is held and after it is released, `out_valid` is 0 and `out_data` is 0 whenever `out_valid` is low. Before the first block start the active length is 0, so every sample sits at position 0 and produces output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_start | input | 1 | Sample is the first of a new block (qualified by in_valid) |
| in_data | input | DW (16) | Signed input sample |
| cfg_we | input | 1 | Load cfg_len and cfg_step into the holding registers |
| cfg_len | input | LW (16) | Window length N |
| cfg_step | input | PW (32) | Phase increment per sample, 2^32/(N−1) |
| out_valid | output | 1 | Windowed sample present this cycle |
| out_data | output | DW (16) | Signed windowed sample, zero when not valid |

## Verification
Two events can fall in the same cycle: a configuration write and a block start. When they coincide, the new length and step must govern the block that begins in that cycle. The bench provokes this by pulsing `cfg_we` together with the first sample of a block, using a length different from the one held. It judges the result from the window values of the whole following block and from where that block wraps back to position 0. A write in the middle of a block is also exercised, and the bench checks that it changes nothing until the next start.

// File: rtl/blackman_cordic_win.sv
module blackman_cordic_win #(
  parameter int DW     = 16,
  parameter int LW     = 16,
  parameter int PW     = 32,
  parameter int AW     = 20,
  parameter int STAGES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic signed [DW-1:0] in_data,
  input  logic                 cfg_we,
  input  logic [LW-1:0]        cfg_len,
  input  logic [PW-1:0]        cfg_step,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);

  localparam int  LAT    = 2*STAGES + 2;
  localparam int  FRAC   = DW + 4;
  localparam int  IW     = FRAC + 4;
  localparam int  SH     = FRAC - DW;
  localparam real TWO_PI = 6.283185307179586;

  typedef logic signed [IW-1:0] sw_t;
  typedef logic signed [AW-1:0] ang_t;

  function automatic real cordic_gain(int n);
    real g;
    g = 1.0;
    for (int i = 0; i < n; i++) g = g * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    return g;
  endfunction

  function automatic logic [STAGES*AW-1:0] atan_table();
    logic [STAGES*AW-1:0] t;
    t = '0;
    for (int i = 0; i < STAGES; i++)
      t[i*AW +: AW] = AW'(longint'($atan(2.0 ** (-1.0 * i)) / TWO_PI * (2.0 ** AW)));
    return t;
  endfunction

  localparam real                  GAIN   = cordic_gain(STAGES);
  localparam logic [STAGES*AW-1:0] ATAB   = atan_table();
  localparam sw_t                  X0     = sw_t'(longint'((2.0 ** FRAC) / (GAIN * GAIN)));
  localparam longint               K_HALF = longint'(0.5 * GAIN * (2.0 ** FRAC));
  localparam longint               K_DC   = longint'(0.42 * (2.0 ** FRAC));
  localparam longint               K_TWO  = longint'(0.08 * (2.0 ** FRAC));
  localparam longint               WMAX   = (longint'(1) <<< DW) - 1;
  localparam longint               OMAX   = (longint'(1) <<< (DW-1)) - 1;
  localparam longint               OMIN   = -(longint'(1) <<< (DW-1));

  function automatic sw_t rot_x(sw_t x, sw_t y, ang_t z, int i);
    return z[AW-1] ? sw_t'(x + (y >>> i)) : sw_t'(x - (y >>> i));
  endfunction

  function automatic sw_t rot_y(sw_t x, sw_t y, ang_t z, int i);
    return z[AW-1] ? sw_t'(y - (x >>> i)) : sw_t'(y + (x >>> i));
  endfunction

  function automatic ang_t rot_z(ang_t z, int i);
    return z[AW-1] ? ang_t'(z + ang_t'(ATAB[i*AW +: AW])) : ang_t'(z - ang_t'(ATAB[i*AW +: AW]));
  endfunction

  // block position and phase
  logic [LW-1:0] sh_len, act_len, idx, eff_len, cur_idx;
  logic [PW-1:0] sh_step, act_step, acc, eff_step, cur_ph;
  logic          wrap;

  assign eff_len  = in_start ? (cfg_we ? cfg_len  : sh_len)  : act_len;
  assign eff_step = in_start ? (cfg_we ? cfg_step : sh_step) : act_step;
  assign cur_idx  = in_start ? '0 : idx;
  assign cur_ph   = in_start ? '0 : acc;
  assign wrap     = ({1'b0, cur_idx} + 1'b1) >= {1'b0, eff_len};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_len <= '0; sh_step <= '0; act_len <= '0; act_step <= '0;
      idx <= '0; acc <= '0;
    end else begin
      if (cfg_we) begin
        sh_len  <= cfg_len;
        sh_step <= cfg_step;
      end
      if (in_valid) begin
        if (in_start) begin
          act_len  <= eff_len;
          act_step <= eff_step;
        end
        idx <= wrap ? '0 : cur_idx + 1'b1;
        acc <= wrap ? '0 : cur_ph + eff_step;
      end
    end
  end

  // fold the phase into [-90,90) degrees; neg flags a half-turn rotation
  logic [AW-1:0] ph_top;
  logic          neg0;
  ang_t          z0;
  assign ph_top = cur_ph[PW-1 -: AW];
  assign neg0   = ph_top[AW-1] ^ ph_top[AW-2];
  assign z0     = ang_t'({ph_top[AW-2], ph_top[AW-2:0]});

  // two chained rotators: A turns (X0,0) by phi, B turns A's result by phi again
  sw_t  ax [1:STAGES], ay [1:STAGES], bx [1:STAGES], by [1:STAGES], bc [1:STAGES];
  ang_t az [1:STAGES], ar [1:STAGES], bz [1:STAGES];
  logic an [1:STAGES];
  sw_t  sax [0:STAGES-1], say [0:STAGES-1], sbx [0:STAGES-1], sby [0:STAGES-1], sbc [0:STAGES-1];
  ang_t saz [0:STAGES-1], sar [0:STAGES-1], sbz [0:STAGES-1];
  logic san [0:STAGES-1];

  always_comb begin
    sax[0] = neg0 ? -X0 : X0;
    say[0] = '0;
    saz[0] = z0;
    sar[0] = z0;
    san[0] = neg0;
    sbx[0] = an[STAGES] ? -ax[STAGES] : ax[STAGES];
    sby[0] = an[STAGES] ? -ay[STAGES] : ay[STAGES];
    sbz[0] = ar[STAGES];
    sbc[0] = ax[STAGES];
    for (int i = 1; i < STAGES; i++) begin
      sax[i] = ax[i]; say[i] = ay[i]; saz[i] = az[i]; sar[i] = ar[i]; san[i] = an[i];
      sbx[i] = bx[i]; sby[i] = by[i]; sbz[i] = bz[i]; sbc[i] = bc[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < STAGES; i++) begin
      ax[i+1] <= rot_x(sax[i], say[i], saz[i], i);
      ay[i+1] <= rot_y(sax[i], say[i], saz[i], i);
      az[i+1] <= rot_z(saz[i], i);
      ar[i+1] <= sar[i];
      an[i+1] <= san[i];
      bx[i+1] <= rot_x(sbx[i], sby[i], sbz[i], i);
      by[i+1] <= rot_y(sbx[i], sby[i], sbz[i], i);
      bz[i+1] <= rot_z(sbz[i], i);
      bc[i+1] <= sbc[i];
    end
  end

  // sample and valid delay lines
  logic signed [DW-1:0] dd [1:LAT-1];
  logic [LAT:1]         vv;
  logic [DW-1:0]        wreg;
  longint               wsum, wq, wcl, prod, rnd, ocl;

  always_comb begin
    wsum = K_DC - ((K_HALF * longint'(bc[STAGES])) >>> FRAC)
                + ((K_TWO * longint'(bx[STAGES])) >>> FRAC);
    wq   = (wsum + (longint'(1) <<< (SH-1))) >>> SH;
    wcl  = (wq < 0) ? 0 : ((wq > WMAX) ? WMAX : wq);
    prod = longint'(dd[LAT-1]) * longint'({1'b0, wreg});
    rnd  = (prod + (longint'(1) <<< (DW-1))) >>> DW;
    ocl  = (rnd > OMAX) ? OMAX : ((rnd < OMIN) ? OMIN : rnd);
  end

  always_ff @(posedge clk) begin
    dd[1] <= in_data;
    for (int k = 2; k < LAT; k++) dd[k] <= dd[k-1];
    wreg <= DW'(wcl);
    if (rst) begin
      vv       <= '0;
      out_data <= '0;
    end else begin
      vv       <= {vv[LAT-1:1], in_valid};
      out_data <= vv[LAT-1] ? DW'(ocl) : '0;
    end
  end

  assign out_valid = vv[LAT];

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (act_len != '0) |-> (idx < act_len));

  // R3
  start_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_start) |=> (idx <= 1));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_start) |=> ($stable(act_len) && $stable(act_step)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(idx) && $stable(acc)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0));

endmodule

// File: tb/blackman_cordic_win_bench.sv
module blackman_cordic_win_bench;
  localparam int  STAGES = 16;
  localparam int  LAT    = 2*STAGES + 2;
  localparam int  TOL    = 6;
  localparam real TWO_PI = 6.283185307179586;

  logic               clk = 0;
  logic               rst = 1;
  logic               in_valid = 0, in_start = 0, cfg_we = 0;
  logic signed [15:0] in_data = '0;
  logic [15:0]        cfg_len = '0;
  logic [31:0]        cfg_step = '0;
  logic               out_valid;
  logic signed [15:0] out_data;

  blackman_cordic_win #(.STAGES(STAGES)) u_blackman_cordic_win (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_step(cfg_step),
    .out_valid(out_valid), .out_data(out_data));

  always #5 clk = ~clk;

  typedef struct { int exp; longint t; string tag; } item_t;
  item_t  q[$];
  longint cyc = 0;
  int     checks = 0, fails = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model state, kept from the requirements
  longint m_shlen = 0, m_actlen = 0, m_idx = 0;
  longint m_shstep = 0, m_actstep = 0, m_acc = 0;

  function automatic longint step_for(int n);
    return longint'((2.0 ** 32) / (n - 1));
  endfunction

  // one cycle of stimulus: called at a negedge, returns at the next negedge
  task automatic tick(bit v, bit s, int x, bit we, int len, longint stp, string tag);
    longint el, es, n, ph;
    real    th, w;
    item_t  it;
    in_valid = v; in_start = s; in_data = 16'(x);
    cfg_we = we; cfg_len = 16'(len); cfg_step = 32'(stp);
    if (v) begin
      el = s ? (we ? len : m_shlen) : m_actlen;
      es = s ? (we ? stp : m_shstep) : m_actstep;
      n  = s ? 0 : m_idx;
      ph = s ? 0 : m_acc;
      th = real'(ph) / (2.0 ** 32);
      w  = 0.42 - 0.5 * $cos(TWO_PI * th) + 0.08 * $cos(2.0 * TWO_PI * th);
      it.exp = int'(real'(x) * w);
      it.t   = cyc;
      it.tag = tag;
      q.push_back(it);
      if (s) begin m_actlen = el; m_actstep = es; end
      if (n + 1 >= el) begin m_idx = 0; m_acc = 0; end
      else begin m_idx = n + 1; m_acc = (ph + es) & 64'hFFFF_FFFF; end
    end
    if (we) begin m_shlen = len; m_shstep = stp; end
    @(negedge clk);
    in_valid = 0; in_start = 0; cfg_we = 0;
  endtask

  task automatic samp(bit s, int x, string tag);
    tick(1'b1, s, x, 1'b0, 0, 0, tag);
  endtask

  task automatic cfg(int len);
    tick(1'b0, 1'b0, 0, 1'b1, len, step_for(len), "R4");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R1: output %0d with no pending input (expected none)", out_data);
        end else begin
          item_t e;
          e = q.pop_front();
          if (cyc - e.t != LAT) begin
            fails++;
            $display("FAIL R1: latency %0d expected %0d", cyc - e.t, LAT);
          end
          checks++;
          if ((int'(out_data) - e.exp > TOL) || (e.exp - int'(out_data) > TOL)) begin
            fails++;
            $display("FAIL %s: out_data %0d expected %0d", e.tag, out_data, e.exp);
          end
        end
      end else begin
        checks++;
        if (out_data != 0) begin
          fails++;
          $display("FAIL R7: idle out_data %0d expected 0", out_data);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (expected completion)");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 16'sd0) begin
      fails++;
      $display("FAIL R7: reset out_valid=%0b out_data=%0d expected 0/0", out_valid, out_data);
    end
    rst = 0;
    @(negedge clk);

    // R7: no block started yet, window is zero
    for (int i = 0; i < 5; i++) samp(1'b0, 12000 + i * 1000, "R7");

    // R2 / R3: N=16, constant input, then wrap without start
    cfg(16);
    for (int i = 0; i < 16; i++) samp(i == 0, 20000, "R2");
    for (int i = 0; i < 16; i++) samp(1'b0, -15000 + i * 1700, "R3");

    // R5: gaps in the stream
    for (int i = 0; i < 36; i++) begin
      if (i % 3 == 1) tick(1'b0, 1'b0, 0, 1'b0, 0, 0, "R5");
      else samp(i == 0, (i * 7919) % 60000 - 30000, "R5");
    end

    // R4: write in the middle of a block is held until the next start
    samp(1'b1, 9000, "R4");
    for (int i = 1; i < 20; i++) begin
      if (i == 5) tick(1'b1, 1'b0, 9000 - i * 300, 1'b1, 33, step_for(33), "R4");
      else samp(1'b0, 9000 - i * 300, "R4");
    end
    for (int i = 0; i < 33; i++) samp(i == 0, 25000 - i * 900, "R4");

    // R4: write in the same cycle as a start applies to that block
    tick(1'b1, 1'b1, 30000, 1'b1, 9, step_for(9), "R4");
    for (int i = 1; i < 12; i++) samp(1'b0, 30000, "R4");

    // R3: restart in the middle of a block
    for (int i = 0; i < 4; i++) samp(i == 0, 16000, "R3");
    for (int i = 0; i < 9; i++) samp(i == 0, 16000, "R3");

    // R6: full scale at both signs, N=17 peaks at position 8
    cfg(17);
    for (int i = 0; i < 17; i++) samp(i == 0, (i % 2) ? -32768 : 32767, "R6");
    for (int i = 0; i < 17; i++) samp(i == 0, (i % 2) ? 32767 : -32768, "R6");

    // R1 / R2: long back-to-back stream, N=64
    cfg(64);
    for (int i = 0; i < 128; i++) samp(i == 0, (i * 4513) % 65000 - 32500, "R1");

    repeat (LAT + 4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d inputs without output, expected 0", q.size());
    end
    done = 1;
    summary();
  end
endmodule